// File: doc/BRIEF.md
# Endian-Aware Load/Store Alignment Unit

This unit sits between a 64-bit core datapath and a byte-addressed memory that is one doubleword wide. Each request carries an address, an access size of 1, 2, 4 or 8 bytes, a load/store selector, a sign-extension flag and a runtime byte-order bit. The order bit selects little-endian or big-endian numbering of the bytes inside a doubleword. The unit checks that the request is naturally aligned. For a store, it asserts the matching byte enables and moves the store data into the correct lanes. For a load, it records where the item sits, then extracts the item from the returned doubleword and widens it to 64 bits.

A misaligned request is never split. It is dropped: the unit issues no memory request, asserts no byte enables and leaves the load result unchanged. One cycle later it raises a single-cycle misalign pulse. Load results are registered and appear one cycle after the memory response strobe.

Top module: `mem_align_unit`

## Requirements
- R1: A request of size s bytes, where s = 2^req_size (req_size 0=byte, 1=half-word, 2=word, 3=doubleword), at address A is aligned exactly when A mod s = 0. In that case, and only when req_valid is high, mem_req_valid is high in the same cycle.
- R2: In the cycle after a valid misaligned request, misalign is high for exactly one cycle. It stays low after aligned requests and in idle cycles.
- R3: A misaligned request leaves mem_req_valid low and mem_be zero. For a load it also leaves ld_data unchanged and ld_valid low.
- R4: In little-endian mode (big_endian=0), a store of s bytes sets exactly s consecutive mem_be bits starting at lane o = A mod 8. Lane L is mem_wdata[8L+7:8L], and mem_be bit L enables lane L.
- R5: In big-endian mode (big_endian=1), address byte o maps to lane 7-o. A store therefore sets s consecutive mem_be bits starting at lane 8-o-s.
- R6: A store places byte k of st_data (k=0 least significant) at lane o+k in little-endian mode, and at lane 7-(o+s-1-k) in big-endian mode. Lanes that are not enabled read zero. Loads assert no byte enables.
- R7: A little-endian load builds result byte k from lane o+k of the returned doubleword, taking the offset and size from the accepted load request.
- R8: A big-endian load builds result byte k from lane 7-(o+s-1-k).
- R9: When req_signed is 1, bits 63 down to 8s of the result copy bit 8s-1 of the item. When req_signed is 0, those bits are zero.
- R10: ld_valid is high in the cycle after mem_rvalid, and ld_data changes only in that cycle.
- R11: Synchronous reset clears ld_data, ld_valid and misalign to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_signed | input | 1 | Sign-extend the load result |
| big_endian | input | 1 | Byte-order mode, 1 = big-endian |
| st_data | input | 64 | Store data, right-justified |
| mem_req_valid | output | 1 | Aligned request issued to memory |
| mem_we | output | 1 | Write strobe for the memory request |
| mem_addr | output | ADDR_W | Doubleword-aligned memory address |
| mem_be | output | 8 | Byte-lane enables for stores |
| mem_wdata | output | 64 | Lane-placed store data |
| mem_rvalid | input | 1 | Memory read response strobe |
| mem_rdata | input | 64 | Returned doubleword |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |
| misalign | output | 1 | One-cycle misalignment flag |

## Verification
The store lanes and enables are combinational, so a wrong lane mapping shows on mem_be and mem_wdata in the same cycle as the request. A corrupted copy of the load context stored at acceptance only shows when the response arrives: ld_data is wrong one cycle after mem_rvalid. The error may be a wrong shift, a wrong extension width or a wrong sign source. A misalign register stuck high, or one that holds for more than one cycle, is visible on the cycle after the request. A load result that changes without a response is visible on the next cycle.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
    localparam int DW    = 64;
    localparam int NLANE = DW / 8;
    localparam int OFF_W = $clog2(NLANE);

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [OFF_W-1:0] shift;
        acc_size_e        size;
        logic             sign_ext;
    } ld_ctx_t;

    function automatic logic [OFF_W:0] size_bytes(acc_size_e sz);
        return (OFF_W+1)'(1) << sz;
    endfunction

    function automatic logic aligned_chk(logic [OFF_W-1:0] off, acc_size_e sz);
        logic [OFF_W:0] m;
        m = size_bytes(sz) - (OFF_W+1)'(1);
        return (({1'b0, off} & m) == '0);
    endfunction

    // Lowest lane occupied by the item
    function automatic logic [OFF_W-1:0] lane_shift(logic [OFF_W-1:0] off, acc_size_e sz,
                                                    logic be_mode);
        logic [OFF_W:0] t;
        if (be_mode) begin
            t = (OFF_W+1)'(NLANE) - {1'b0, off} - size_bytes(sz);
            return t[OFF_W-1:0];
        end
        return off;
    endfunction
endpackage

// File: rtl/lane_map.sv
module lane_map
    import lsu_align_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    input  logic             big_endian,
    output logic             aligned,
    output logic [OFF_W-1:0] shift,
    output logic [NLANE-1:0] mask
);
    logic [OFF_W+1:0] lo_lane;
    logic [OFF_W+1:0] hi_lane;

    always_comb begin
        aligned = aligned_chk(off, size);
        shift   = lane_shift(off, size, big_endian);
        lo_lane = {2'b00, shift};
        hi_lane = {2'b00, shift} + {1'b0, size_bytes(size)};
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign mask[i] = ((OFF_W+2)'(i) >= lo_lane) && ((OFF_W+2)'(i) < hi_lane);
    end
endmodule

// File: rtl/store_pack.sv
module store_pack
    import lsu_align_pkg::*;
(
    input  logic [OFF_W-1:0] shift,
    input  logic [NLANE-1:0] mask,
    input  logic [DW-1:0]    st_data,
    output logic [DW-1:0]    wdata
);
    logic [DW-1:0] shifted;

    always_comb shifted = st_data << {shift, 3'b000};

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign wdata[8*i +: 8] = mask[i] ? shifted[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import lsu_align_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  ld_ctx_t       ctx_in,
    input  logic          rvalid,
    input  logic [DW-1:0] rdata,
    output logic          ld_valid,
    output logic [DW-1:0] ld_data
);
    ld_ctx_t       ctx_q;
    logic [DW-1:0] raw;
    logic [DW-1:0] ext;
    logic          sgn;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (capture) begin
            ctx_q <= ctx_in;
        end
    end

    always_comb begin
        raw = rdata >> {ctx_q.shift, 3'b000};
        sgn = 1'b0;
        ext = raw;
        case (ctx_q.size)
            SZ_B: begin
                sgn = ctx_q.sign_ext & raw[7];
                ext = {{(DW-8){sgn}}, raw[7:0]};
            end
            SZ_H: begin
                sgn = ctx_q.sign_ext & raw[15];
                ext = {{(DW-16){sgn}}, raw[15:0]};
            end
            SZ_W: begin
                sgn = ctx_q.sign_ext & raw[31];
                ext = {{(DW-32){sgn}}, raw[31:0]};
            end
            default: ext = raw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= rvalid;
            if (rvalid) ld_data <= ext;
        end
    end

    // R10: result strobe follows the response strobe by one cycle
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> ld_valid);
    // R10: no result change without a strobe
    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> $stable(ld_data));
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              big_endian,
    input  logic [63:0]       st_data,
    output logic              mem_req_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_be,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              ld_valid,
    output logic [63:0]       ld_data,
    output logic              misalign
);
    acc_size_e        size;
    logic [OFF_W-1:0] off;
    logic             aligned;
    logic [OFF_W-1:0] shift;
    logic [NLANE-1:0] mask;
    logic [DW-1:0]    packed_wdata;
    logic             hit;
    ld_ctx_t          ctx;

    assign size = acc_size_e'(req_size);
    assign off  = req_addr[OFF_W-1:0];

    lane_map u_map (
        .off        (off),
        .size       (size),
        .big_endian (big_endian),
        .aligned    (aligned),
        .shift      (shift),
        .mask       (mask)
    );

    store_pack u_pack (
        .shift   (shift),
        .mask    (mask),
        .st_data (st_data),
        .wdata   (packed_wdata)
    );

    always_comb begin
        hit           = req_valid & aligned;
        mem_req_valid = hit;
        mem_we        = hit & req_is_store;
        mem_addr      = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_be        = (hit & req_is_store) ? mask : '0;
        mem_wdata     = (hit & req_is_store) ? packed_wdata : '0;
        ctx.shift     = shift;
        ctx.size      = size;
        ctx.sign_ext  = req_signed;
    end

    always_ff @(posedge clk) begin
        if (rst) misalign <= 1'b0;
        else     misalign <= req_valid & ~aligned;
    end

    load_extract u_load (
        .clk      (clk),
        .rst      (rst),
        .capture  (hit & ~req_is_store),
        .ctx_in   (ctx),
        .rvalid   (mem_rvalid),
        .rdata    (mem_rdata),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

    // R4: a store enables as many lanes as it has bytes
    p_be_count_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_store && aligned) |-> ($countones(mem_be) == int'(size_bytes(size))));
    // R2: a misaligned request raises the flag on the next cycle
    p_misalign_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !aligned) |=> misalign);
    // R3: a flagged request produced no memory traffic
    p_misalign_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        misalign |-> ($past(mem_be) == '0 && !$past(mem_req_valid)));
    // R6: loads never drive byte enables
    p_load_no_be_r6: assert property (@(posedge clk) disable iff (rst)
        !req_is_store |-> (mem_be == '0));
endmodule

// File: tb/mem_align_unit_bench.sv
module mem_align_unit_bench;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid, req_is_store, req_signed, big_endian;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic [63:0]       st_data;
    logic              mem_req_valid, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_be;
    logic [63:0]       mem_wdata;
    logic              mem_rvalid;
    logic [63:0]       mem_rdata;
    logic              ld_valid;
    logic [63:0]       ld_data;
    logic              misalign;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    mem_align_unit #(.ADDR_W(ADDR_W)) u_mem_align_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
        .big_endian(big_endian), .st_data(st_data), .mem_req_valid(mem_req_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data), .misalign(misalign)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int lane_of(int o, int s, int k, bit be);
        return be ? 7 - (o + s - 1 - k) : o + k;
    endfunction

    function automatic logic [63:0] exp_load(int o, int s, bit sgn, bit be, logic [63:0] rd);
        logic [63:0] item = '0;
        for (int k = 0; k < 8; k++)
            if (k < s) item[k*8 +: 8] = rd[lane_of(o, s, k, be)*8 +: 8];
        if (sgn && item[s*8-1])
            for (int b = 0; b < 64; b++)
                if (b >= s*8) item[b] = 1'b1;
        return item;
    endfunction

    task automatic do_store(logic [31:0] addr, int sz, bit be, logic [63:0] d);
        int s = 1 << sz;
        int o = int'(addr[2:0]);
        bit al = (addr % s) == 0;
        logic [7:0]  ebe = '0;
        logic [63:0] ewd = '0;
        @(negedge clk);
        req_valid = 1; req_is_store = 1; req_addr = addr; req_size = 2'(sz);
        req_signed = 0; big_endian = be; st_data = d;
        #1;
        check("R1 store req_valid", 64'(mem_req_valid), 64'(al));
        if (al) begin
            for (int k = 0; k < s; k++) begin
                ebe[lane_of(o, s, k, be)] = 1'b1;
                ewd[lane_of(o, s, k, be)*8 +: 8] = d[k*8 +: 8];
            end
            check(be ? "R5 store be" : "R4 store be", 64'(mem_be), 64'(ebe));
            check("R6 store data", mem_wdata, ewd);
        end else begin
            check("R3 misaligned store be", 64'(mem_be), 64'h0);
        end
        @(negedge clk);
        req_valid = 0;
        check("R2 misalign after store", 64'(misalign), 64'(!al));
    endtask

    task automatic do_load(logic [31:0] addr, int sz, bit sgn, bit be, logic [63:0] rd);
        int s = 1 << sz;
        int o = int'(addr[2:0]);
        bit al = (addr % s) == 0;
        logic [63:0] prev;
        @(negedge clk);
        req_valid = 1; req_is_store = 0; req_addr = addr; req_size = 2'(sz);
        req_signed = sgn; big_endian = be; st_data = $urandom;
        #1;
        check("R1 load req_valid", 64'(mem_req_valid), 64'(al));
        check("R6 load be zero", 64'(mem_be), 64'h0);
        prev = ld_data;
        @(negedge clk);
        req_valid = 0;
        big_endian = ~be;
        req_size = ~req_size;
        check("R2 misalign after load", 64'(misalign), 64'(!al));
        if (al) begin
            mem_rvalid = 1; mem_rdata = rd;
            @(negedge clk);
            mem_rvalid = 0;
            check("R10 ld_valid", 64'(ld_valid), 64'h1);
            check(be ? "R8 R9 big-endian load" : "R7 R9 little-endian load",
                  ld_data, exp_load(o, s, sgn, be, rd));
            prev = ld_data;
            @(negedge clk);
            check("R2 misalign single cycle", 64'(misalign), 64'h0);
            check("R10 ld_valid drop", 64'(ld_valid), 64'h0);
            check("R10 ld_data hold", ld_data, prev);
        end else begin
            @(negedge clk);
            check("R2 misalign single cycle", 64'(misalign), 64'h0);
            check("R3 misaligned load data", ld_data, prev);
            check("R3 misaligned load valid", 64'(ld_valid), 64'h0);
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; req_valid = 0; req_is_store = 0; req_addr = '0; req_size = '0;
        req_signed = 0; big_endian = 0; st_data = '0; mem_rvalid = 0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        check("R11 reset ld_data", ld_data, 64'h0);
        check("R11 reset ld_valid", 64'(ld_valid), 64'h0);
        check("R11 reset misalign", 64'(misalign), 64'h0);
        rst = 0;

        // directed corners
        do_store(32'h100, 3, 0, 64'h0807060504030201);
        do_store(32'h104, 2, 0, 64'hAABBCCDD11223344);
        do_store(32'h104, 2, 1, 64'hAABBCCDD11223344);
        for (int o = 0; o < 8; o++) do_store(32'h200 + o, 0, o[0], 64'h5A);
        do_store(32'h201, 1, 0, 64'h1234);
        do_store(32'h206, 2, 1, 64'h1234);
        do_load(32'h300, 0, 1, 0, 64'h0000_0000_0000_0080);
        do_load(32'h300, 0, 0, 0, 64'h0000_0000_0000_0080);
        do_load(32'h307, 0, 1, 1, 64'h80FF_FFFF_FFFF_FF7F);
        do_load(32'h304, 2, 1, 0, 64'h8765_4321_0000_0000);
        do_load(32'h304, 2, 1, 1, 64'h0000_0000_8765_4321);
        do_load(32'h302, 1, 0, 1, 64'h0000_FFEE_0000_0000);
        do_load(32'h308, 3, 1, 1, 64'hF0E1_D2C3_B4A5_9687);
        do_load(32'h303, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_load(32'h30C, 3, 1, 0, 64'h1);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a = $urandom;
            int sz = int'($urandom_range(0, 3));
            bit be = 1'($urandom);
            if ($urandom_range(0, 3) != 0) a = a & ~((32'd1 << sz) - 1);
            if ($urandom_range(0, 1) == 0)
                do_store(a, sz, be, {$urandom, $urandom});
            else
                do_load(a, sz, 1'($urandom), be, {$urandom, $urandom});
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule